// File: doc/BRIEF.md
# Shared Cell Buffer Manager

This block holds frames for a group of ports in one common pool of fixed-size cells. Each ingress port offers a frame one cell per beat and names the egress port the frame is for. Every stored cell is taken from a common free list, so a port that receives heavy traffic can take most of the pool while an idle port holds no cells at all. No cell is set aside for any particular port.

The cells of a frame are chained through a next-cell pointer table. A frame is private to its ingress port until its last cell arrives. At that point the whole chain is appended to the FIFO queue of the destination port in a single step. Cells stay in that queue until the egress port signals ready. Each cell is then read out and goes back to the free list in the same cycle.

If the pool runs dry partway through a frame, the cells that frame already took go back to the free list at once, the frame is reported as dropped, and its remaining beats are absorbed up to its last cell. One ingress beat and one egress cell are served per cycle, each chosen round-robin.

Top module: `shared_cell_buffer`

## Requirements
- R1: After reset, `free_cells` equals NUM_CELLS, every `q_depth` entry is 0, and `in_ready`, `eg_valid` and `drop_evt` are all 0.
- R2: At most one bit of `in_ready` is set in any cycle, and only for a port whose `in_valid` is high. When several ports request at once, the grant rotates round-robin so that every requester is served.
- R3: An accepted beat that is stored takes exactly one cell from the pool, and `free_cells` drops by one in the next cycle. No cells are reserved per port, so a single port may fill all but the cells other traffic holds.
- R4: A frame does not count toward any queue depth until its last beat (`in_last`=1) is accepted. In the following cycle, the `q_depth` of its destination grows by the frame's full cell count.
- R5: A queued cell stays in the pool, and its queue depth is unchanged, for as long as the egress port keeps `eg_ready` low.
- R6: At most one bit of `eg_valid` is set per cycle, and only for a port with `eg_ready` high and a nonempty queue. In that cycle, `eg_data`, `eg_last` and `eg_bytes` show that queue's head cell. The cell is delivered and returned, so `free_cells` rises by one in the next cycle.
- R7: Each egress queue delivers frames in the order their last beats were accepted, and delivers the cells of a frame in their arrival order.
- R8: `eg_bytes` reports the `in_bytes` value that came with a frame's last cell. Every cell that is not last reports CELL_BYTES (64 by default).
- R9: A beat that arrives while `free_cells` is 0 for a frame not already dropped aborts that frame. Its held cells go back to the pool, and the next cycle shows the restored `free_cells` and a one-cycle pulse on that port's `drop_evt` bit. Later beats of the frame, up to and including its last, are accepted and discarded and never reach a queue.
- R10: When a cell is stored and another is delivered in the same cycle, `free_cells` is unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N_PORTS | Ingress beat offered, one bit per port |
| in_ready | output | N_PORTS | Ingress beat accepted this cycle (one-hot) |
| in_dest | input | N_PORTS*PORT_W | Destination port, sampled on a frame's first beat |
| in_data | input | N_PORTS*CELL_BYTES*8 | Cell payload per ingress port |
| in_last | input | N_PORTS | Beat is the frame's final cell |
| in_bytes | input | N_PORTS*BC_W | Valid byte count of a final cell |
| eg_ready | input | N_PORTS | Egress port can take a cell |
| eg_valid | output | N_PORTS | Cell delivered to this egress port this cycle (one-hot) |
| eg_data | output | CELL_BYTES*8 | Payload of the delivered cell |
| eg_last | output | 1 | Delivered cell ends its frame |
| eg_bytes | output | BC_W | Valid bytes in the delivered cell |
| free_cells | output | CNT_W | Cells currently on the free list |
| q_depth | output | N_PORTS*CNT_W | Cells queued for each egress port |
| drop_evt | output | N_PORTS | One-cycle pulse when a port's frame is aborted |

## Verification
The hardest case to reach from the ports is pool exhaustion in the middle of a frame. Reaching it needs a nearly full pool, a frame that already holds cells, and no egress draining at that moment. The bench gets there by parking a large frame for one egress port while that port's ready stays low. A second port then sends a multi-cell frame, whose second beat meets an empty free list. The bench checks the pulse, the restored count and the discarded tail. It then sends a fresh frame and drains both queues, which shows that the returned cells are reusable and the aborted cells never entered a queue. A separate cycle drives a store and a delivery together so that the free count can be checked across the collision.

// File: rtl/cb_pkg.sv
package cb_pkg;

    // What the ingress side does with the granted beat in a cycle
    typedef enum logic [1:0] {
        ING_IDLE    = 2'd0,
        ING_STORE   = 2'd1,
        ING_DISCARD = 2'd2,
        ING_ABORT   = 2'd3
    } ing_op_e;

endpackage

// File: rtl/cb_rr_arb.sv
module cb_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [PW-1:0] last;
    } arb_t;

    arb_t arb_d, arb_q;

    always_comb begin
        logic found;
        int   idx;
        arb_d = arb_q;
        gnt   = '0;
        found = 1'b0;
        for (int off = 1; off <= N; off++) begin
            idx = (int'(arb_q.last) + off) % N;
            if (!found && req[idx]) begin
                found         = 1'b1;
                gnt[idx]      = 1'b1;
                arb_d.last    = PW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) arb_q <= '{last: PW'(N - 1)};
        else        arb_q <= arb_d;
    end
endmodule

// File: rtl/cb_cell_store.sv
module cb_cell_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 512
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [WIDTH-1:0]         wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [WIDTH-1:0]         rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/shared_cell_buffer.sv
module shared_cell_buffer
    import cb_pkg::*;
#(
    parameter int N_PORTS    = 4,
    parameter int NUM_CELLS  = 16,
    parameter int CELL_BYTES = 64,
    localparam int CELL_W = CELL_BYTES * 8,
    localparam int PORT_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
    localparam int CNT_W  = $clog2(NUM_CELLS + 1),
    localparam int BC_W   = $clog2(CELL_BYTES + 1)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [N_PORTS-1:0]               in_valid,
    output logic [N_PORTS-1:0]               in_ready,
    input  logic [N_PORTS-1:0][PORT_W-1:0]   in_dest,
    input  logic [N_PORTS-1:0][CELL_W-1:0]   in_data,
    input  logic [N_PORTS-1:0]               in_last,
    input  logic [N_PORTS-1:0][BC_W-1:0]     in_bytes,
    input  logic [N_PORTS-1:0]               eg_ready,
    output logic [N_PORTS-1:0]               eg_valid,
    output logic [CELL_W-1:0]                eg_data,
    output logic                             eg_last,
    output logic [BC_W-1:0]                  eg_bytes,
    output logic [CNT_W-1:0]                 free_cells,
    output logic [N_PORTS-1:0][CNT_W-1:0]    q_depth,
    output logic [N_PORTS-1:0]               drop_evt
);
    localparam int IDX_W = $clog2(NUM_CELLS);
    localparam int WORD_W = CELL_W + 1 + BC_W;

    typedef struct packed {
        logic [NUM_CELLS-1:0][IDX_W-1:0] nxt;
        logic [IDX_W-1:0]                fhead;
        logic [CNT_W-1:0]                fcnt;
        logic [N_PORTS-1:0][IDX_W-1:0]   qhead;
        logic [N_PORTS-1:0][IDX_W-1:0]   qtail;
        logic [N_PORTS-1:0][CNT_W-1:0]   qcnt;
        logic [N_PORTS-1:0][IDX_W-1:0]   phead;
        logic [N_PORTS-1:0][IDX_W-1:0]   ptail;
        logic [N_PORTS-1:0][CNT_W-1:0]   pcnt;
        logic [N_PORTS-1:0][PORT_W-1:0]  pdest;
        logic [N_PORTS-1:0]              pdrop;
        logic [N_PORTS-1:0]              drop;
    } state_t;

    function automatic state_t reset_state();
        state_t s;
        s       = '0;
        s.fcnt  = CNT_W'(NUM_CELLS);
        for (int i = 0; i < NUM_CELLS; i++) s.nxt[i] = IDX_W'((i + 1) % NUM_CELLS);
        return s;
    endfunction

    state_t st_d, st_q;

    logic [N_PORTS-1:0] ing_gnt, eg_req, eg_gnt;
    logic [PORT_W-1:0]  ip, ep;
    ing_op_e            op;
    logic               mem_we;
    logic [WORD_W-1:0]  mem_wdata, mem_rdata;
    logic [BC_W-1:0]    bytes_eff;

    cb_rr_arb #(.N(N_PORTS)) i_ing_arb (
        .clk(clk), .rst_n(rst_n), .req(in_valid), .gnt(ing_gnt)
    );

    for (genvar g = 0; g < N_PORTS; g++) begin : g_egreq
        assign eg_req[g] = eg_ready[g] && (st_q.qcnt[g] != '0);
    end

    cb_rr_arb #(.N(N_PORTS)) i_eg_arb (
        .clk(clk), .rst_n(rst_n), .req(eg_req), .gnt(eg_gnt)
    );

    // Grant vectors to indices
    always_comb begin
        ip = '0;
        ep = '0;
        for (int i = 0; i < N_PORTS; i++) begin
            if (ing_gnt[i]) ip = PORT_W'(i);
            if (eg_gnt[i])  ep = PORT_W'(i);
        end
    end

    always_comb begin
        if (!(|ing_gnt))              op = ING_IDLE;
        else if (st_q.pdrop[ip])      op = ING_DISCARD;
        else if (st_q.fcnt == '0)     op = ING_ABORT;
        else                          op = ING_STORE;
    end

    assign bytes_eff = in_last[ip] ? in_bytes[ip] : BC_W'(CELL_BYTES);
    assign mem_we    = (op == ING_STORE);
    assign mem_wdata = {in_last[ip], bytes_eff, in_data[ip]};

    cb_cell_store #(.DEPTH(NUM_CELLS), .WIDTH(WORD_W)) i_store (
        .clk(clk), .we(mem_we), .waddr(st_q.fhead), .wdata(mem_wdata),
        .raddr(st_q.qhead[ep]), .rdata(mem_rdata)
    );

    // Next-state computation
    always_comb begin
        logic [IDX_W-1:0]  fh, n, c, fr_head;
        logic [CNT_W-1:0]  fc, fr_len;
        logic [PORT_W-1:0] dq;
        st_d      = st_q;
        st_d.drop = '0;
        fh        = st_q.fhead;
        fc        = st_q.fcnt;
        c         = st_q.qhead[ep];
        n         = st_q.fhead;
        fr_head   = '0;
        fr_len    = '0;
        dq        = '0;

        // Egress queue side: pop head of the granted queue
        if (|eg_gnt) begin
            st_d.qcnt[ep]  = st_q.qcnt[ep] - CNT_W'(1);
            st_d.qhead[ep] = st_q.nxt[c];
        end

        unique case (op)
            ING_STORE: begin
                fh = st_q.nxt[n];
                fc = fc - CNT_W'(1);
                if (st_q.pcnt[ip] == '0) begin
                    st_d.phead[ip] = n;
                    st_d.pdest[ip] = in_dest[ip];
                end else begin
                    st_d.nxt[st_q.ptail[ip]] = n;
                end
                st_d.ptail[ip] = n;
                st_d.pcnt[ip]  = st_q.pcnt[ip] + CNT_W'(1);
                if (in_last[ip]) begin
                    fr_head = st_d.phead[ip];
                    fr_len  = st_d.pcnt[ip];
                    dq      = st_d.pdest[ip];
                    if (st_d.qcnt[dq] == '0) st_d.qhead[dq] = fr_head;
                    else                     st_d.nxt[st_d.qtail[dq]] = fr_head;
                    st_d.qtail[dq] = n;
                    st_d.qcnt[dq]  = st_d.qcnt[dq] + fr_len;
                    st_d.pcnt[ip]  = '0;
                end
            end
            ING_ABORT: begin
                if (st_q.pcnt[ip] != '0) begin
                    st_d.nxt[st_q.ptail[ip]] = fh;
                    fh = st_q.phead[ip];
                    fc = fc + st_q.pcnt[ip];
                end
                st_d.pcnt[ip]  = '0;
                st_d.drop[ip]  = 1'b1;
                st_d.pdrop[ip] = !in_last[ip];
            end
            ING_DISCARD: begin
                if (in_last[ip]) st_d.pdrop[ip] = 1'b0;
            end
            default: ;
        endcase

        // Delivered cell goes back to the free list
        if (|eg_gnt) begin
            st_d.nxt[c] = fh;
            fh = c;
            fc = fc + CNT_W'(1);
        end

        st_d.fhead = fh;
        st_d.fcnt  = fc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end

    assign in_ready   = ing_gnt;
    assign eg_valid   = eg_gnt;
    assign eg_data    = mem_rdata[CELL_W-1:0];
    assign eg_bytes   = mem_rdata[CELL_W +: BC_W];
    assign eg_last    = mem_rdata[WORD_W-1];
    assign free_cells = st_q.fcnt;
    assign q_depth    = st_q.qcnt;
    assign drop_evt   = st_q.drop;
endmodule

// File: rtl/shared_cell_buffer_chk.sv
module shared_cell_buffer_chk #(
    parameter int N_PORTS   = 4,
    parameter int NUM_CELLS = 16,
    parameter int CNT_W     = 5
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [N_PORTS-1:0]            in_valid,
    input logic [N_PORTS-1:0]            in_ready,
    input logic [N_PORTS-1:0]            eg_ready,
    input logic [N_PORTS-1:0]            eg_valid,
    input logic [CNT_W-1:0]              free_cells,
    input logic [N_PORTS-1:0][CNT_W-1:0] q_depth,
    input logic [N_PORTS-1:0]            drop_evt
);
    logic past_ok;
    always_ff @(posedge clk) past_ok <= rst_n;

    // R2
    ing_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_ready));

    // R2
    ing_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready & ~in_valid) == '0);

    // R6
    eg_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eg_valid));

    // R6
    for (genvar p = 0; p < N_PORTS; p++) begin : g_eg
        eg_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
            eg_valid[p] |-> (eg_ready[p] && q_depth[p] != '0));
        // R9
        drop_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && drop_evt[p]) |-> ($past(free_cells) == '0));
    end

    // R3
    pool_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_cells <= CNT_W'(NUM_CELLS));

    // R10
    free_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && drop_evt == '0) |->
        ((free_cells == $past(free_cells)) ||
         (free_cells == $past(free_cells) + CNT_W'(1)) ||
         (free_cells + CNT_W'(1) == $past(free_cells))));
endmodule

bind shared_cell_buffer shared_cell_buffer_chk #(
    .N_PORTS(N_PORTS), .NUM_CELLS(NUM_CELLS), .CNT_W(CNT_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .eg_ready(eg_ready), .eg_valid(eg_valid), .free_cells(free_cells),
    .q_depth(q_depth), .drop_evt(drop_evt)
);

// File: tb/test_shared_cell_buffer.sv
module test_shared_cell_buffer;
    localparam int N      = 4;
    localparam int CELLS  = 16;
    localparam int CB     = 64;
    localparam int CW     = CB * 8;
    localparam int PW     = 2;
    localparam int CNTW   = 5;
    localparam int BCW    = 7;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [N-1:0]            in_valid = '0;
    logic [N-1:0]            in_ready;
    logic [N-1:0][PW-1:0]    in_dest = '0;
    logic [N-1:0][CW-1:0]    in_data = '0;
    logic [N-1:0]            in_last = '0;
    logic [N-1:0][BCW-1:0]   in_bytes = '0;
    logic [N-1:0]            eg_ready = '0;
    logic [N-1:0]            eg_valid;
    logic [CW-1:0]           eg_data;
    logic                    eg_last;
    logic [BCW-1:0]          eg_bytes;
    logic [CNTW-1:0]         free_cells;
    logic [N-1:0][CNTW-1:0]  q_depth;
    logic [N-1:0]            drop_evt;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    shared_cell_buffer #(.N_PORTS(N), .NUM_CELLS(CELLS), .CELL_BYTES(CB)) i_shared_cell_buffer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_dest(in_dest), .in_data(in_data), .in_last(in_last), .in_bytes(in_bytes),
        .eg_ready(eg_ready), .eg_valid(eg_valid), .eg_data(eg_data), .eg_last(eg_last),
        .eg_bytes(eg_bytes), .free_cells(free_cells), .q_depth(q_depth), .drop_evt(drop_evt)
    );

    function automatic logic [CW-1:0] pat(input logic [31:0] tag);
        return {16{tag}};
    endfunction

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_cell(input int p, input int dest, input logic [31:0] tag,
                             input logic last, input int bytes);
        int tmo;
        @(negedge clk);
        in_valid[p] = 1'b1;
        in_dest[p]  = PW'(dest);
        in_data[p]  = pat(tag);
        in_last[p]  = last;
        in_bytes[p] = BCW'(bytes);
        tmo = 0;
        #1;
        while (!in_ready[p] && tmo < 100) begin
            @(negedge clk); #1; tmo++;
        end
        chk(in_ready[p], "R2 ingress grant", longint'(in_ready), longint'(1 << p));
        @(posedge clk); #1;
        in_valid[p] = 1'b0;
    endtask

    task automatic pull(input int p, input logic [31:0] tag, input logic last,
                        input int bytes, input string req);
        @(negedge clk);
        eg_ready[p] = 1'b1;
        #1;
        chk(eg_valid[p], req, longint'(eg_valid), longint'(1 << p));
        chk(eg_data == pat(tag), req, longint'(eg_data[31:0]), longint'(tag));
        chk(eg_last == last, "R8 last flag", longint'(eg_last), longint'(last));
        chk(eg_bytes == BCW'(bytes), "R8 byte count", longint'(eg_bytes), longint'(bytes));
        @(posedge clk); #1;
        eg_ready[p] = 1'b0;
    endtask

    task automatic expect_state(input int fr, input int p, input int dep, input string req);
        @(negedge clk);
        chk(free_cells == CNTW'(fr), req, longint'(free_cells), longint'(fr));
        chk(q_depth[p] == CNTW'(dep), req, longint'(q_depth[p]), longint'(dep));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(free_cells == CNTW'(CELLS), "R1 free", longint'(free_cells), CELLS);
        chk(q_depth == '0, "R1 depth", longint'(q_depth), 0);
        chk(in_ready == '0 && eg_valid == '0 && drop_evt == '0, "R1 strobes",
            longint'({in_ready, eg_valid, drop_evt}), 0);
    endtask

    task automatic t_single_hold();
        send_cell(0, 2, 32'h11, 1'b1, 40);
        expect_state(15, 2, 1, "R3 store one cell");
        repeat (5) @(posedge clk);
        expect_state(15, 2, 1, "R5 held without ready");
        pull(2, 32'h11, 1'b1, 40, "R6 deliver head");
        expect_state(16, 2, 0, "R6 cell returned");
    endtask

    task automatic t_order();
        send_cell(1, 3, 32'h21, 1'b0, 0);
        send_cell(1, 3, 32'h22, 1'b0, 0);
        expect_state(14, 3, 0, "R4 partial frame not queued");
        send_cell(1, 3, 32'h23, 1'b1, 7);
        expect_state(13, 3, 3, "R4 frame linked on last");
        send_cell(0, 3, 32'h31, 1'b0, 0);
        send_cell(0, 3, 32'h32, 1'b1, 64);
        expect_state(11, 3, 5, "R4 second frame");
        pull(3, 32'h21, 1'b0, CB, "R7 order 1");
        pull(3, 32'h22, 1'b0, CB, "R7 order 2");
        pull(3, 32'h23, 1'b1, 7,  "R7 order 3");
        pull(3, 32'h31, 1'b0, CB, "R7 order 4");
        pull(3, 32'h32, 1'b1, 64, "R7 order 5");
        expect_state(16, 3, 0, "R7 drained");
    endtask

    task automatic t_arb();
        int first;
        int second;
        @(negedge clk);
        in_valid[1] = 1'b1; in_dest[1] = 2'd0; in_data[1] = pat(32'h51); in_last[1] = 1'b1; in_bytes[1] = 7'd5;
        in_valid[3] = 1'b1; in_dest[3] = 2'd0; in_data[3] = pat(32'h53); in_last[3] = 1'b1; in_bytes[3] = 7'd5;
        #1;
        chk($countones(in_ready) == 1 && (in_ready & 4'b1010) != 0, "R2 single grant",
            longint'(in_ready), 0);
        first = in_ready[1] ? 1 : 3;
        second = (first == 1) ? 3 : 1;
        @(posedge clk); #1;
        in_valid[first] = 1'b0;
        @(negedge clk); #1;
        chk(in_ready == 4'(1 << second), "R2 rotation", longint'(in_ready), longint'(1 << second));
        @(posedge clk); #1;
        in_valid[second] = 1'b0;
        expect_state(14, 0, 2, "R2 both stored");
        pull(0, 32'h50 + 32'(first), 1'b1, 5, "R7 arb order 1");
        pull(0, 32'h50 + 32'(second), 1'b1, 5, "R7 arb order 2");
        expect_state(16, 0, 0, "R6 drained");
    endtask

    task automatic t_drop();
        for (int i = 0; i < 15; i++) send_cell(0, 1, 32'h100 + 32'(i), (i == 14), 1);
        expect_state(1, 1, 15, "R3 one port takes most of pool");
        send_cell(2, 0, 32'h200, 1'b0, 0);
        expect_state(0, 0, 0, "R3 last free cell taken");
        send_cell(2, 0, 32'h201, 1'b0, 0);
        @(negedge clk);
        chk(drop_evt == 4'b0100, "R9 drop pulse", longint'(drop_evt), 4);
        chk(free_cells == CNTW'(1), "R9 cells released", longint'(free_cells), 1);
        send_cell(2, 0, 32'h202, 1'b1, 3);
        expect_state(1, 0, 0, "R9 tail discarded");
        chk(drop_evt == '0, "R9 pulse one cycle", longint'(drop_evt), 0);
        send_cell(3, 0, 32'h300, 1'b1, 9);
        expect_state(0, 0, 1, "R9 pool reusable");
        pull(0, 32'h300, 1'b1, 9, "R9 no aborted cells queued");
        for (int i = 0; i < 15; i++)
            pull(1, 32'h100 + 32'(i), (i == 14), (i == 14) ? 1 : CB, "R7 long frame order");
        expect_state(16, 1, 0, "R6 all returned");
    endtask

    task automatic t_concurrent();
        send_cell(1, 2, 32'h41, 1'b1, 10);
        send_cell(1, 2, 32'h42, 1'b1, 11);
        expect_state(14, 2, 2, "R10 setup");
        @(negedge clk);
        in_valid[0] = 1'b1; in_dest[0] = 2'd2; in_data[0] = pat(32'h43); in_last[0] = 1'b1; in_bytes[0] = 7'd12;
        eg_ready[2] = 1'b1;
        #1;
        chk(in_ready[0] && eg_valid[2], "R10 both sides active", longint'({in_ready, eg_valid}), 0);
        chk(eg_data == pat(32'h41), "R10 head delivered", longint'(eg_data[31:0]), 32'h41);
        @(posedge clk); #1;
        in_valid[0] = 1'b0;
        eg_ready[2] = 1'b0;
        expect_state(14, 2, 2, "R10 count consistent");
        pull(2, 32'h42, 1'b1, 11, "R7 after collision 1");
        pull(2, 32'h43, 1'b1, 12, "R7 after collision 2");
        expect_state(16, 2, 0, "R10 drained");
    endtask

    initial begin
        #(200000 * 8);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_single_hold();
        t_order();
        t_arb();
        t_drop();
        t_concurrent();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule